// File: doc/BRIEF.md
# Two-Slot Pipelined Stub Lookup Chain

This block turns raw track-stub bit patterns into global tracking values by passing each stub through two lookup tables in series. The first table's output is the address into the second table. Both tables are writable, so they can carry alignment corrections.

The block runs on a fast clock at twice the bunch-crossing rate. On each crossing, two stubs (A and B) arrive side by side, marked by a one-cycle crossing strobe. They are sent one after the other through a single table chain: A in the first fast slot and B in the second. The two results are then gathered back into a parallel pair. Every result carries its own valid flag.

The tables are loaded through a simple write port. That port only takes effect while the hold input is high. Any result that passes through the chain during hold is marked invalid.

Top module: `stub_lut_chain`

## Requirements
- R1: After reset is released, both result valid outputs are low until the first crossing has propagated.
- R2: A stub pair presented together with the strobe in fast cycle n appears at the result outputs in cycle n+7, that is, 7 rising edges later. It stays there for two cycles. The strobe is never high in two consecutive cycles.
- R3: Each valid result equals second_table[first_table[stub]]. The first table is indexed by the stub word, and its entry indexes the second table.
- R4: The result of stub A always appears on res_a_o and the result of stub B on res_b_o, even when the two stubs differ.
- R5: A stub presented with its valid flag low gives a low result valid flag. The other stub of the same crossing is still transformed normally.
- R6: With hold_i high, a pulse of wr_en_i writes wr_data_i at wr_addr_i. wr_sel_i=0 selects the first table and wr_sel_i=1 selects the second. Lookups made after hold is released use the new contents.
- R7: A write pulse while hold_i is low has no effect on either table.
- R8: Every result whose stubs entered while hold_i was high comes out with its valid flag low.
- R9: Strobes every second cycle give a full-rate stream, with one result pair per crossing and no lost or swapped pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock, twice the crossing rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| xing_i | input | 1 | Crossing strobe, marks slot 0 of a crossing |
| stub_a_i | input | 8 | Stub A word |
| stub_a_vld_i | input | 1 | Stub A valid |
| stub_b_i | input | 8 | Stub B word |
| stub_b_vld_i | input | 1 | Stub B valid |
| hold_i | input | 1 | Hold lookups and allow table writes |
| wr_en_i | input | 1 | Table write pulse |
| wr_sel_i | input | 1 | Table select: 0 first, 1 second |
| wr_addr_i | input | 8 | Table write address |
| wr_data_i | input | 12 | Table write data (first table uses low 8 bits) |
| res_a_o | output | 12 | Result for stub A |
| res_a_vld_o | output | 1 | Result A valid |
| res_b_o | output | 12 | Result for stub B |
| res_b_vld_o | output | 1 | Result B valid |

## Verification
A wrong slot tag or phase register inside the chain shows up at the ports as swapped A and B results, or as a result pair that never updates. This is visible at the first result pair, in cycle n+7. A miscounted stage shifts the output update by one fast cycle. The bench catches this by watching a valid-low pair give way to a valid-high pair exactly between cycles n+8 and n+9. A table entry written to the wrong place, or written while hold is low, gives a wrong result word the first time that entry is looked up.

// File: rtl/stub_lut_pkg.sv
package stub_lut_pkg;
  typedef struct packed {
    logic vld;
    logic slot;
  } slot_tag_t;

  function automatic int max_of(input int x, input int y);
    return (x > y) ? x : y;
  endfunction
endpackage

// File: rtl/stub_serializer.sv
module stub_serializer
  import stub_lut_pkg::*;
#(
  parameter int STUB_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              xing_i,
  input  logic              hold_i,
  input  logic [STUB_W-1:0] stub_a_i,
  input  logic              stub_a_vld_i,
  input  logic [STUB_W-1:0] stub_b_i,
  input  logic              stub_b_vld_i,
  output logic [STUB_W-1:0] ser_data_o,
  output slot_tag_t         ser_tag_o
);
  logic              phase_q, phase_d;
  logic [STUB_W-1:0] b_q, b_d;
  logic              bv_q, bv_d;
  logic [STUB_W-1:0] data_q, data_d;
  slot_tag_t         tag_q, tag_d;
  logic              data_en;

  always_comb begin
    phase_d = xing_i;
    b_d     = xing_i ? stub_b_i : b_q;
    bv_d    = xing_i ? (stub_b_vld_i & ~hold_i) : bv_q;
    data_en = xing_i | phase_q;
    data_d  = data_q;
    tag_d   = '0;
    if (xing_i) begin
      data_d   = stub_a_i;
      tag_d.vld  = stub_a_vld_i & ~hold_i;
      tag_d.slot = 1'b0;
    end else if (phase_q) begin
      data_d   = b_q;
      tag_d.vld  = bv_q & ~hold_i;
      tag_d.slot = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= 1'b0;
      bv_q    <= 1'b0;
      tag_q   <= '0;
    end else begin
      phase_q <= phase_d;
      bv_q    <= bv_d;
      tag_q   <= tag_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (xing_i)  b_q    <= b_d;
    if (data_en) data_q <= data_d;
  end

  assign ser_data_o = data_q;
  assign ser_tag_o  = tag_q;

  // R2
  xing_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xing_i |=> !xing_i);
  // R4
  slot_b_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ser_tag_o.slot |-> $past(xing_i, 2));
endmodule

// File: rtl/stub_lut_stage.sv
module stub_lut_stage
  import stub_lut_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          hold_i,
  input  logic [AW-1:0] in_data_i,
  input  slot_tag_t     in_tag_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  output logic [DW-1:0] out_data_o,
  output slot_tag_t     out_tag_o
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] addr_q, addr_d;
  logic [DW-1:0] data_q, data_d;
  slot_tag_t     tag1_q, tag1_d, tag2_q, tag2_d;
  logic          wr_fire;

  always_comb begin
    wr_fire    = wr_en_i & hold_i;
    addr_d     = in_data_i;
    tag1_d     = in_tag_i;
    tag1_d.vld = in_tag_i.vld & ~hold_i;
    data_d     = mem_q[addr_q];
    tag2_d     = tag1_q;
    tag2_d.vld = tag1_q.vld & ~hold_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tag1_q <= '0;
      tag2_q <= '0;
    end else begin
      tag1_q <= tag1_d;
      tag2_q <= tag2_d;
    end
  end

  always_ff @(posedge clk_i) begin
    addr_q <= addr_d;
    data_q <= data_d;
    if (wr_fire) mem_q[wr_addr_i] <= wr_data_i;
  end

  assign out_data_o = data_q;
  assign out_tag_o  = tag2_q;

  // R8
  hold_invalid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i |=> !out_tag_o.vld);
  // R2
  stage_lat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_tag_o.slot == $past(in_tag_i.slot, 2));
endmodule

// File: rtl/stub_deserializer.sv
module stub_deserializer
  import stub_lut_pkg::*;
#(
  parameter int DW = 12
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] in_data_i,
  input  slot_tag_t     in_tag_i,
  output logic          upd_o,
  output logic [DW-1:0] res_a_o,
  output logic          res_a_vld_o,
  output logic [DW-1:0] res_b_o,
  output logic          res_b_vld_o
);
  logic [DW-1:0] a_q, a_d;
  logic          av_q, av_d;
  logic [DW-1:0] ra_q, ra_d, rb_q, rb_d;
  logic          rav_q, rav_d, rbv_q, rbv_d;
  logic          cap_a, upd;

  always_comb begin
    cap_a = ~in_tag_i.slot;
    upd   = in_tag_i.slot;
    a_d   = cap_a ? in_data_i    : a_q;
    av_d  = cap_a ? in_tag_i.vld : av_q;
    ra_d  = upd ? a_q          : ra_q;
    rav_d = upd ? av_q         : rav_q;
    rb_d  = upd ? in_data_i    : rb_q;
    rbv_d = upd ? in_tag_i.vld : rbv_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      av_q  <= 1'b0;
      rav_q <= 1'b0;
      rbv_q <= 1'b0;
    end else begin
      av_q  <= av_d;
      rav_q <= rav_d;
      rbv_q <= rbv_d;
    end
  end

  always_ff @(posedge clk_i) begin
    if (cap_a) a_q <= a_d;
    if (upd) begin
      ra_q <= ra_d;
      rb_q <= rb_d;
    end
  end

  assign upd_o       = upd;
  assign res_a_o     = ra_q;
  assign res_a_vld_o = rav_q;
  assign res_b_o     = rb_q;
  assign res_b_vld_o = rbv_q;

  // R4
  slot_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_tag_i.slot |-> !$past(in_tag_i.slot));
endmodule

// File: rtl/stub_lut_chain.sv
module stub_lut_chain
  import stub_lut_pkg::*;
#(
  parameter int STUB_W = 8,
  parameter int MID_W  = 8,
  parameter int OUT_W  = 12,
  localparam int WA_W  = max_of(STUB_W, MID_W),
  localparam int WD_W  = max_of(MID_W, OUT_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             xing_i,
  input  logic [STUB_W-1:0] stub_a_i,
  input  logic             stub_a_vld_i,
  input  logic [STUB_W-1:0] stub_b_i,
  input  logic             stub_b_vld_i,
  input  logic             hold_i,
  input  logic             wr_en_i,
  input  logic             wr_sel_i,
  input  logic [WA_W-1:0]  wr_addr_i,
  input  logic [WD_W-1:0]  wr_data_i,
  output logic [OUT_W-1:0] res_a_o,
  output logic             res_a_vld_o,
  output logic [OUT_W-1:0] res_b_o,
  output logic             res_b_vld_o
);
  localparam int NSTAGE = 2;

  logic [1:0]       rst_sync_q;
  logic             rst_n;
  logic [NSTAGE-1:0] stage_we;
  logic [STUB_W-1:0] ser_data;
  slot_tag_t        ser_tag, s1_tag, s2_tag;
  logic [MID_W-1:0] s1_data;
  logic [OUT_W-1:0] s2_data;
  logic             deser_upd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  for (genvar g = 0; g < NSTAGE; g++) begin : g_we
    assign stage_we[g] = wr_en_i & (wr_sel_i == 1'(g));
  end

  stub_serializer #(.STUB_W(STUB_W)) ser_i (
    .clk_i(clk_i), .rst_ni(rst_n), .xing_i(xing_i), .hold_i(hold_i),
    .stub_a_i(stub_a_i), .stub_a_vld_i(stub_a_vld_i),
    .stub_b_i(stub_b_i), .stub_b_vld_i(stub_b_vld_i),
    .ser_data_o(ser_data), .ser_tag_o(ser_tag)
  );

  stub_lut_stage #(.AW(STUB_W), .DW(MID_W)) lut1_i (
    .clk_i(clk_i), .rst_ni(rst_n), .hold_i(hold_i),
    .in_data_i(ser_data), .in_tag_i(ser_tag),
    .wr_en_i(stage_we[0]), .wr_addr_i(wr_addr_i[STUB_W-1:0]),
    .wr_data_i(wr_data_i[MID_W-1:0]),
    .out_data_o(s1_data), .out_tag_o(s1_tag)
  );

  stub_lut_stage #(.AW(MID_W), .DW(OUT_W)) lut2_i (
    .clk_i(clk_i), .rst_ni(rst_n), .hold_i(hold_i),
    .in_data_i(s1_data), .in_tag_i(s1_tag),
    .wr_en_i(stage_we[1]), .wr_addr_i(wr_addr_i[MID_W-1:0]),
    .wr_data_i(wr_data_i[OUT_W-1:0]),
    .out_data_o(s2_data), .out_tag_o(s2_tag)
  );

  stub_deserializer #(.DW(OUT_W)) deser_i (
    .clk_i(clk_i), .rst_ni(rst_n),
    .in_data_i(s2_data), .in_tag_i(s2_tag), .upd_o(deser_upd),
    .res_a_o(res_a_o), .res_a_vld_o(res_a_vld_o),
    .res_b_o(res_b_o), .res_b_vld_o(res_b_vld_o)
  );

  // R2
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $past(xing_i, 6) |-> deser_upd);
  // R9
  no_extra_upd_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    deser_upd |-> $past(xing_i, 6));
endmodule

// File: tb/stub_lut_chain_tb_top.sv
module stub_lut_chain_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xing = 1'b0;
  logic [7:0] sa = '0, sb = '0;
  logic va = 1'b0, vb = 1'b0;
  logic hold = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0;
  logic [7:0] wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic [11:0] ra, rb;
  logic rav, rbv;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [7:0]  t1 [256];
  logic [11:0] t2 [256];
  logic [7:0]  qa [16], qb [16];
  logic        qva [16], qvb [16];

  always #5 clk = ~clk;

  stub_lut_chain dut_i (
    .clk_i(clk), .rst_ni(rst_n), .xing_i(xing),
    .stub_a_i(sa), .stub_a_vld_i(va), .stub_b_i(sb), .stub_b_vld_i(vb),
    .hold_i(hold), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .res_a_o(ra), .res_a_vld_o(rav), .res_b_o(rb), .res_b_vld_o(rbv)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
      summary();
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_tab(input logic sel, input logic [7:0] addr, input logic [11:0] data);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_addr = addr; wr_data = data;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  function automatic logic [11:0] model(input logic [7:0] s);
    return t2[t1[s]];
  endfunction

  // drive n crossings back to back and check each pair at cycle n+7
  task automatic stream(input int n, input logic hold_exp, input string req);
    fork
      begin
        for (int k = 0; k < n; k++) begin
          @(negedge clk);
          xing = 1'b1; sa = qa[k]; sb = qb[k]; va = qva[k]; vb = qvb[k];
          @(negedge clk);
          xing = 1'b0; va = 1'b0; vb = 1'b0;
        end
      end
      begin
        repeat (8) @(negedge clk);
        for (int k = 0; k < n; k++) begin
          check({req, " valid_a"}, 32'(rav), 32'(qva[k] & ~hold_exp));
          check({req, " valid_b"}, 32'(rbv), 32'(qvb[k] & ~hold_exp));
          if (qva[k] && !hold_exp) check({req, " res_a"}, 32'(ra), 32'(model(qa[k])));
          if (qvb[k] && !hold_exp) check({req, " res_b"}, 32'(rb), 32'(model(qb[k])));
          if (k < n - 1) repeat (2) @(negedge clk);
        end
      end
    join
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 valid_a after reset", 32'(rav), 0);
    check("R1 valid_b after reset", 32'(rbv), 0);
  endtask

  task automatic t_load();
    hold = 1'b1;
    for (int i = 0; i < 256; i++) begin
      t1[i] = 8'($urandom);
      t2[i] = 12'($urandom);
      write_tab(1'b0, 8'(i), {4'h0, t1[i]});
      write_tab(1'b1, 8'(i), t2[i]);
    end
    @(negedge clk);
    hold = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_basic();
    for (int k = 0; k < 4; k++) begin
      qa[k] = 8'($urandom); qb[k] = qa[k] ^ 8'h5A; qva[k] = 1'b1; qvb[k] = 1'b1;
    end
    stream(4, 1'b0, "R3 R4 distinct pair");
    repeat (4) @(negedge clk);
  endtask

  task automatic t_latency();
    fork
      begin
        @(negedge clk);
        xing = 1'b1; sa = 8'h11; sb = 8'h22; va = 1'b0; vb = 1'b0;
        @(negedge clk);
        xing = 1'b0;
        @(negedge clk);
        xing = 1'b1; sa = 8'h33; sb = 8'h44; va = 1'b1; vb = 1'b1;
        @(negedge clk);
        xing = 1'b0; va = 1'b0; vb = 1'b0;
      end
      begin
        repeat (9) @(negedge clk);
        check("R2 not yet at cycle n+6", 32'(rav), 0);
        @(negedge clk);
        check("R2 valid at cycle n+7", 32'(rav), 1);
        check("R2 res_a at cycle n+7", 32'(ra), 32'(model(8'h33)));
        @(negedge clk);
        check("R2 held second cycle", 32'(rb), 32'(model(8'h44)));
      end
    join
    repeat (4) @(negedge clk);
  endtask

  task automatic t_valid_mix();
    for (int k = 0; k < 6; k++) begin
      qa[k] = 8'($urandom); qb[k] = 8'($urandom);
      qva[k] = (k % 2 == 0); qvb[k] = (k % 3 != 0);
    end
    stream(6, 1'b0, "R5 per-slot valid");
    repeat (4) @(negedge clk);
  endtask

  task automatic t_throughput();
    for (int k = 0; k < 12; k++) begin
      qa[k] = 8'($urandom); qb[k] = 8'($urandom); qva[k] = 1'b1; qvb[k] = 1'b1;
    end
    stream(12, 1'b0, "R9 back to back");
    repeat (4) @(negedge clk);
  endtask

  task automatic t_hold_invalid();
    hold = 1'b1;
    for (int k = 0; k < 3; k++) begin
      qa[k] = 8'($urandom); qb[k] = 8'($urandom); qva[k] = 1'b1; qvb[k] = 1'b1;
    end
    stream(3, 1'b1, "R8 hold");
    @(negedge clk);
    hold = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_write_ignored();
    logic [7:0] s;
    s = 8'h9C;
    write_tab(1'b0, s, {4'h0, ~t1[s]});
    write_tab(1'b1, t1[s], ~t2[t1[s]]);
    repeat (2) @(negedge clk);
    qa[0] = s; qb[0] = s; qva[0] = 1'b1; qvb[0] = 1'b1;
    stream(1, 1'b0, "R7 write without hold");
    repeat (4) @(negedge clk);
  endtask

  task automatic t_write_hold();
    logic [7:0] s;
    s = 8'h3E;
    hold = 1'b1;
    t1[s] = t1[s] + 8'd7;
    write_tab(1'b0, s, {4'h0, t1[s]});
    t2[t1[s]] = t2[t1[s]] ^ 12'hA5A;
    write_tab(1'b1, t1[s], t2[t1[s]]);
    @(negedge clk);
    hold = 1'b0;
    repeat (2) @(negedge clk);
    qa[0] = s; qb[0] = 8'h3F; qva[0] = 1'b1; qvb[0] = 1'b1;
    stream(1, 1'b0, "R6 write with hold");
    repeat (4) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_load();
    t_basic();
    t_latency();
    t_valid_mix();
    t_throughput();
    t_hold_invalid();
    t_write_ignored();
    t_write_hold();
    summary();
  end
endmodule